// File: doc/BRIEF.md
# UART Host Register and Interrupt Logic

This block is the register layer that sits between a host bus and the serial side of a UART that runs without DMA. It keeps one transmit holding register and one receive buffer register, each with its own flag. The host sees whether the holding register can take a new character and whether a fresh character is waiting. A simple single-cycle register bus carries the host's reads and writes. The line side has three connections: a load handshake to an external transmit shifter, a push from an external receive deserializer, and pulse inputs for receive errors and modem status changes.

All four interrupt sources share one request line. There is an enable bit for each source, and an identification register tells the host which enabled source has the highest priority. The sources are: receive error, data ready, transmit empty and modem change. A read that returns a register also clears that register's own interrupt source. Writing a full holding register replaces the waiting character. Reading an empty buffer returns the last character again.

Register map (offsets on `host_addr_i`): 0 = data (a write goes to the holding register, a read comes from the receive buffer), 1 = interrupt enable (read/write), 2 = interrupt identification (read only), 3 = line status (read only), 4 = modem status (read only). Any other offset reads as zero.

Top module: `uart_hostreg`

## Requirements
- R1: After reset, line status reads 0x08 and the enable register reads 0x00. With no source enabled, identification reads 0x01. `irq_o` and `tx_load_o` are low.
- R2: A host write to offset 0 fills the holding register and clears the transmit-empty flag (line status bit 3). A second write made before the shifter takes the first character replaces it, and the replaced character is never loaded.
- R3: In any cycle where the holding register is full and `tx_idle_i` is high, `tx_load_o` is high and `tx_data_o` carries the held character. The transmit-empty flag reads 1 from the next cycle on.
- R4: A `rx_valid_i` pulse stores `rx_data_i` in the receive buffer and sets data-ready (line status bit 0). A host read of offset 0 returns that character and clears data-ready.
- R5: Reading offset 0 while data-ready is 0 returns the last received character and changes no flag.
- R6: If `rx_valid_i` arrives while data-ready is 1 and the host is not reading offset 0 in that cycle, the overrun bit (line status bit 1) sets and the new character replaces the old one. A line status read clears the overrun bit.
- R7: A `rx_err_i` pulse sets line status bit 2, which stays set until the next line status read. A `modem_chg_i` pulse sets modem status bit 0, which stays set until the next modem status read.
- R8: Enable bits are: bit 0 data ready, bit 1 transmit empty, bit 2 receive error (overrun or line error), bit 3 modem change. `irq_o` is the OR of the enabled pending sources, registered. It rises one clock after a source becomes pending and falls one clock after the last one clears.
- R9: Identification reports only enabled pending sources, in this priority order: error 0x06, data ready 0x04, transmit empty 0x02, modem 0x00. It reads 0x01 when no enabled source is pending.
- R10: Transmit-empty pending is set at reset and each time the holding register is emptied by a load. It is cleared by a write to offset 0, or by an identification read that returns 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel_i | input | 1 | Bus access in this cycle |
| host_wr_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | ADDR_W | Register offset |
| host_wdata_i | input | DATA_W | Write data |
| host_rdata_o | output | DATA_W | Read data, combinational for the current access |
| tx_idle_i | input | 1 | Transmit shifter can accept a character |
| tx_load_o | output | 1 | Holding register hands its character to the shifter |
| tx_data_o | output | DATA_W | Character being handed over |
| rx_valid_i | input | 1 | Deserializer delivers a character |
| rx_data_i | input | DATA_W | Delivered character |
| rx_err_i | input | 1 | Receive error pulse (framing, parity, break) |
| modem_chg_i | input | 1 | Modem line change pulse |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest states to reach are the ones where several sources are pending at once. The identification register then has to step down the priority list as each one is serviced. The stimulus builds this state on purpose: it leaves transmit-empty pending after a real shifter load, then injects a character, a receive error and a modem change before any read. Each read then clears one source, and the bench checks the next code in order. A second hard case is showing that an overwritten holding-register character never reaches the shifter. For this the shifter is held busy across two writes, and every load seen at the line side is counted.

// File: rtl/uart_hostreg_pkg.sv
package uart_hostreg_pkg;
   // register offsets
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_IEN  = 1;
   localparam int unsigned OFS_IID  = 2;
   localparam int unsigned OFS_LST  = 3;
   localparam int unsigned OFS_MST  = 4;

   // enable / cause bit positions
   localparam int unsigned SRC_RX  = 0;
   localparam int unsigned SRC_TX  = 1;
   localparam int unsigned SRC_ERR = 2;
   localparam int unsigned SRC_MDM = 3;
   localparam int unsigned NUM_SRC = 4;

   typedef logic [NUM_SRC-1:0] src_vec_t;

   // identification codes
   localparam logic [3:0] IID_NONE = 4'h1;
   localparam logic [3:0] IID_ERR  = 4'h6;
   localparam logic [3:0] IID_RX   = 4'h4;
   localparam logic [3:0] IID_TX   = 4'h2;
   localparam logic [3:0] IID_MDM  = 4'h0;

   // line status bit positions
   localparam int unsigned LST_DR  = 0;
   localparam int unsigned LST_OVR = 1;
   localparam int unsigned LST_ERR = 2;
   localparam int unsigned LST_TXE = 3;
endpackage

// File: rtl/uhr_tx_hold.sv
module uhr_tx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              idle_i,
   output logic              load_o,
   output logic [DATA_W-1:0] data_o,
   output logic              full_o,
   output logic              emptied_o
);
   logic              full_q;
   logic [DATA_W-1:0] hold_q;

   assign load_o    = full_q & idle_i;
   assign emptied_o = load_o & ~wr_i;
   assign data_o    = hold_q;
   assign full_o    = full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         hold_q <= '0;
      end else begin
         if (wr_i) begin
            full_q <= 1'b1;
            hold_q <= wdata_i;
         end else if (load_o) begin
            full_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/uhr_rx_buf.sv
module uhr_rx_buf #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] pdata_i,
   input  logic              rd_i,
   input  logic              err_i,
   input  logic              clr_err_i,
   output logic [DATA_W-1:0] data_o,
   output logic              ready_o,
   output logic              ovr_o,
   output logic              lerr_o
);
   logic [DATA_W-1:0] buf_q;
   logic              rdy_q;
   logic              ovr_q;
   logic              lerr_q;

   assign data_o  = buf_q;
   assign ready_o = rdy_q;
   assign ovr_o   = ovr_q;
   assign lerr_o  = lerr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         rdy_q  <= 1'b0;
         ovr_q  <= 1'b0;
         lerr_q <= 1'b0;
      end else begin
         if (push_i) begin
            buf_q <= pdata_i;
            rdy_q <= 1'b1;
         end else if (rd_i) begin
            rdy_q <= 1'b0;
         end
         if (push_i && rdy_q && !rd_i) ovr_q <= 1'b1;
         else if (clr_err_i)          ovr_q <= 1'b0;
         if (err_i)          lerr_q <= 1'b1;
         else if (clr_err_i) lerr_q <= 1'b0;
      end
   end
endmodule

// File: rtl/uhr_irq.sv
module uhr_irq
   import uart_hostreg_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  src_vec_t   ena_i,
   input  logic       tx_set_i,
   input  logic       tx_clr_i,
   input  logic       iid_rd_i,
   input  logic       err_i,
   input  logic       rx_i,
   input  logic       mdm_i,
   output logic [3:0] iid_o,
   output logic       irq_o
);
   logic     tx_pend_q;
   src_vec_t pend;
   src_vec_t act;

   always_comb begin
      pend          = '0;
      pend[SRC_RX]  = rx_i;
      pend[SRC_TX]  = tx_pend_q;
      pend[SRC_ERR] = err_i;
      pend[SRC_MDM] = mdm_i;
      act           = pend & ena_i;
      if      (act[SRC_ERR]) iid_o = IID_ERR;
      else if (act[SRC_RX])  iid_o = IID_RX;
      else if (act[SRC_TX])  iid_o = IID_TX;
      else if (act[SRC_MDM]) iid_o = IID_MDM;
      else                   iid_o = IID_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              tx_pend_q <= 1'b1;
      else if (tx_set_i)                       tx_pend_q <= 1'b1;
      else if (tx_clr_i)                       tx_pend_q <= 1'b0;
      else if (iid_rd_i && iid_o == IID_TX)    tx_pend_q <= 1'b0;
   end

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |act;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         assign irq_o = |act;
      end
   endgenerate
endmodule

// File: rtl/uart_hostreg.sv
module uart_hostreg
   import uart_hostreg_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 3,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel_i,
   input  logic              host_wr_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   input  logic [DATA_W-1:0] host_wdata_i,
   output logic [DATA_W-1:0] host_rdata_o,
   input  logic              tx_idle_i,
   output logic              tx_load_o,
   output logic [DATA_W-1:0] tx_data_o,
   input  logic              rx_valid_i,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              rx_err_i,
   input  logic              modem_chg_i,
   output logic              irq_o
);
   localparam int unsigned LST_W = LST_TXE + 1;

   generate
      if (DATA_W < NUM_SRC) begin : g_bad_data
         $error("DATA_W must hold the enable and identification fields");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must reach offset 4");
      end
   endgenerate

   logic              wr_data, rd_data, wr_ien, rd_iid, rd_lst, rd_mst;
   logic              thr_full, tx_emptied;
   logic [DATA_W-1:0] rbr_data;
   logic              dr, ovr, lerr;
   src_vec_t          ien_q;
   logic              mdm_q;
   logic [3:0]        iid;
   logic [LST_W-1:0]  lst;

   always_comb begin
      wr_data = host_sel_i &  host_wr_i & (host_addr_i == ADDR_W'(OFS_DATA));
      rd_data = host_sel_i & ~host_wr_i & (host_addr_i == ADDR_W'(OFS_DATA));
      wr_ien  = host_sel_i &  host_wr_i & (host_addr_i == ADDR_W'(OFS_IEN));
      rd_iid  = host_sel_i & ~host_wr_i & (host_addr_i == ADDR_W'(OFS_IID));
      rd_lst  = host_sel_i & ~host_wr_i & (host_addr_i == ADDR_W'(OFS_LST));
      rd_mst  = host_sel_i & ~host_wr_i & (host_addr_i == ADDR_W'(OFS_MST));
   end

   uhr_tx_hold #(.DATA_W(DATA_W)) tx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_data),
      .wdata_i   (host_wdata_i),
      .idle_i    (tx_idle_i),
      .load_o    (tx_load_o),
      .data_o    (tx_data_o),
      .full_o    (thr_full),
      .emptied_o (tx_emptied)
   );

   uhr_rx_buf #(.DATA_W(DATA_W)) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (rx_valid_i),
      .pdata_i   (rx_data_i),
      .rd_i      (rd_data),
      .err_i     (rx_err_i),
      .clr_err_i (rd_lst),
      .data_o    (rbr_data),
      .ready_o   (dr),
      .ovr_o     (ovr),
      .lerr_o    (lerr)
   );

   uhr_irq #(.IRQ_REG(IRQ_REG)) irq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ena_i    (ien_q),
      .tx_set_i (tx_emptied),
      .tx_clr_i (wr_data),
      .iid_rd_i (rd_iid),
      .err_i    (ovr | lerr),
      .rx_i     (dr),
      .mdm_i    (mdm_q),
      .iid_o    (iid),
      .irq_o    (irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
         mdm_q <= 1'b0;
      end else begin
         if (wr_ien) ien_q <= host_wdata_i[NUM_SRC-1:0];
         if (modem_chg_i) mdm_q <= 1'b1;
         else if (rd_mst) mdm_q <= 1'b0;
      end
   end

   always_comb begin
      lst          = '0;
      lst[LST_DR]  = dr;
      lst[LST_OVR] = ovr;
      lst[LST_ERR] = lerr;
      lst[LST_TXE] = ~thr_full;
      host_rdata_o = '0;
      if (host_sel_i && !host_wr_i) begin
         case (host_addr_i)
            ADDR_W'(OFS_DATA): host_rdata_o = rbr_data;
            ADDR_W'(OFS_IEN):  host_rdata_o = DATA_W'(ien_q);
            ADDR_W'(OFS_IID):  host_rdata_o = DATA_W'(iid);
            ADDR_W'(OFS_LST):  host_rdata_o = DATA_W'(lst);
            ADDR_W'(OFS_MST):  host_rdata_o = DATA_W'(mdm_q);
            default:           host_rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/uhr_checker.sv
module uhr_checker #(
   parameter bit IRQ_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_data,
   input logic       rd_data,
   input logic       wr_ien,
   input logic       tx_idle_i,
   input logic       thr_full,
   input logic       rx_valid_i,
   input logic       dr,
   input logic       ovr,
   input logic       ien_rx,
   input logic       irq_o
);
   AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> thr_full); // R2

   AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_full && tx_idle_i && !wr_data) |=> !thr_full); // R3

   AST_PUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_i |=> dr); // R4

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_valid_i) |=> !dr); // R4

   AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && dr && !rd_data) |=> ovr); // R6

   generate
      if (IRQ_REG) begin : g_irq_chk
         AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid_i && ien_rx && !wr_ien) |=> ##1 irq_o); // R8
      end
   endgenerate
endmodule

bind uart_hostreg uhr_checker #(.IRQ_REG(IRQ_REG)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .wr_ien     (wr_ien),
   .tx_idle_i  (tx_idle_i),
   .thr_full   (thr_full),
   .rx_valid_i (rx_valid_i),
   .dr         (dr),
   .ovr        (ovr),
   .ien_rx     (ien_q[0]),
   .irq_o      (irq_o)
);

// File: tb/uart_hostreg_tb_top.sv
module uart_hostreg_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel_i = 1'b0;
   logic       host_wr_i = 1'b0;
   logic [2:0] host_addr_i = '0;
   logic [7:0] host_wdata_i = '0;
   logic [7:0] host_rdata_o;
   logic       tx_idle_i = 1'b0;
   logic       tx_load_o;
   logic [7:0] tx_data_o;
   logic       rx_valid_i = 1'b0;
   logic [7:0] rx_data_i = '0;
   logic       rx_err_i = 1'b0;
   logic       modem_chg_i = 1'b0;
   logic       irq_o;

   int checks = 0;
   int errors = 0;
   int loads = 0;
   logic [7:0] last_load = '0;
   logic [7:0] rd;

   always #5 clk = ~clk;

   uart_hostreg dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_sel_i   (host_sel_i),
      .host_wr_i    (host_wr_i),
      .host_addr_i  (host_addr_i),
      .host_wdata_i (host_wdata_i),
      .host_rdata_o (host_rdata_o),
      .tx_idle_i    (tx_idle_i),
      .tx_load_o    (tx_load_o),
      .tx_data_o    (tx_data_o),
      .rx_valid_i   (rx_valid_i),
      .rx_data_i    (rx_data_i),
      .rx_err_i     (rx_err_i),
      .modem_chg_i  (modem_chg_i),
      .irq_o        (irq_o)
   );

   // shifter-side monitor, sampled just before each rising edge
   always @(negedge clk) begin
      #4;
      if (tx_load_o === 1'b1) begin
         loads++;
         last_load = tx_data_o;
      end
   end

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      host_sel_i = 1'b1; host_wr_i = 1'b1; host_addr_i = a; host_wdata_i = d;
      @(posedge clk); #1;
      host_sel_i = 1'b0; host_wr_i = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      host_sel_i = 1'b1; host_wr_i = 1'b0; host_addr_i = a;
      #1 d = host_rdata_o;
      @(posedge clk); #1;
      host_sel_i = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] d);
      @(negedge clk);
      rx_valid_i = 1'b1; rx_data_i = d;
      @(posedge clk); #1;
      rx_valid_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk); #1;
   endtask

   // {write, addr, wdata, expected read}
   localparam logic [19:0] VEC [7] = '{
      {1'b1, 3'd1, 8'h0F, 8'h00},   // R8 enable all
      {1'b0, 3'd1, 8'h00, 8'h0F},   // R8 enable readback
      {1'b1, 3'd1, 8'h02, 8'h00},   // R10 only tx-empty
      {1'b0, 3'd2, 8'h00, 8'h02},   // R10 pending from reset
      {1'b0, 3'd2, 8'h00, 8'h01},   // R10 cleared by that read
      {1'b1, 3'd1, 8'h00, 8'h00},
      {1'b0, 3'd3, 8'h00, 8'h08}    // R1 line status idle
   };

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      idle(1);

      // R1 reset state
      check("R1 irq", {7'd0, irq_o}, 8'h00);
      check("R1 load", {7'd0, tx_load_o}, 8'h00);
      bus_rd(3'd2, rd); check("R1 iid", rd, 8'h01);
      bus_rd(3'd3, rd); check("R1 lst", rd, 8'h08);
      bus_rd(3'd1, rd); check("R1 ien", rd, 8'h00);

      foreach (VEC[i]) begin
         if (VEC[i][19]) bus_wr(VEC[i][18:16], VEC[i][15:8]);
         else begin
            bus_rd(VEC[i][18:16], rd);
            check($sformatf("R9 table[%0d]", i), rd, VEC[i][7:0]);
         end
      end

      // R2 overwrite while shifter busy
      bus_wr(3'd0, 8'hA5);
      bus_rd(3'd3, rd); check("R2 txe cleared", rd, 8'h00);
      bus_wr(3'd0, 8'h3C);
      check("R2 no load while busy", 8'(loads), 8'd0);
      // R3 handover
      @(negedge clk); tx_idle_i = 1'b1; #1;
      check("R3 load strobe", {7'd0, tx_load_o}, 8'h01);
      check("R3 load data", tx_data_o, 8'h3C);
      idle(1);
      check("R3 load gone", {7'd0, tx_load_o}, 8'h00);
      bus_rd(3'd3, rd); check("R3 txe set", rd, 8'h08);
      check("R2 one load", 8'(loads), 8'd1);
      check("R2 overwritten char", last_load, 8'h3C);

      // R10 tx-empty pending re-armed by the load
      bus_wr(3'd1, 8'h02);
      idle(1);
      check("R8 irq tx", {7'd0, irq_o}, 8'h01);
      bus_rd(3'd2, rd); check("R10 iid tx", rd, 8'h02);
      idle(1);
      check("R10 irq cleared", {7'd0, irq_o}, 8'h00);
      bus_rd(3'd2, rd); check("R10 iid none", rd, 8'h01);
      bus_wr(3'd0, 8'h77);
      idle(3);
      check("R10 rearm after load", {7'd0, irq_o}, 8'h01);
      check("R3 second load", last_load, 8'h77);
      bus_wr(3'd1, 8'h00);

      // R4 / R5 receive path
      rx_push(8'h5A);
      bus_rd(3'd3, rd); check("R4 dr set", rd, 8'h09);
      bus_rd(3'd0, rd); check("R4 data", rd, 8'h5A);
      bus_rd(3'd3, rd); check("R4 dr cleared", rd, 8'h08);
      bus_rd(3'd0, rd); check("R5 stale data", rd, 8'h5A);
      bus_rd(3'd3, rd); check("R5 flags unchanged", rd, 8'h08);

      // R6 overrun
      rx_push(8'h11);
      rx_push(8'h22);
      bus_rd(3'd3, rd); check("R6 overrun", rd, 8'h0B);
      bus_rd(3'd3, rd); check("R6 overrun cleared", rd, 8'h09);
      bus_rd(3'd0, rd); check("R6 newest char", rd, 8'h22);

      // R7 / R9 priority walk with all sources pending
      bus_wr(3'd1, 8'h0F);
      rx_push(8'h33);
      @(negedge clk); rx_err_i = 1'b1; modem_chg_i = 1'b1;
      @(posedge clk); #1; rx_err_i = 1'b0; modem_chg_i = 1'b0;
      idle(1);
      check("R8 irq all", {7'd0, irq_o}, 8'h01);
      bus_rd(3'd2, rd); check("R9 iid err", rd, 8'h06);
      bus_rd(3'd3, rd); check("R7 line err", rd, 8'h0D);
      bus_rd(3'd2, rd); check("R9 iid rx", rd, 8'h04);
      bus_rd(3'd0, rd); check("R4 data 33", rd, 8'h33);
      bus_rd(3'd2, rd); check("R9 iid tx", rd, 8'h02);
      bus_rd(3'd2, rd); check("R9 iid mdm", rd, 8'h00);
      bus_rd(3'd4, rd); check("R7 modem", rd, 8'h01);
      bus_rd(3'd4, rd); check("R7 modem cleared", rd, 8'h00);
      bus_rd(3'd2, rd); check("R9 iid none", rd, 8'h01);
      idle(1);
      check("R8 irq off", {7'd0, irq_o}, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule